// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Less-Than

This block is a purely combinational integer ALU of parameterised width, 32 bits by default. It is built from a chain of identical one-bit slices. Every slice takes one bit from each operand, can optionally invert its `b` bit, and adds the bits with a ripple carry. It then picks its result bit from four candidates: the bitwise AND, the bitwise OR, the sum bit, or a `less` input. The top slice also derives a signed-overflow flag and a "set" bit. The set bit is wired back to the `less` input of bit 0. The `less` inputs of all other slices are tied low.

The datapath executes add, subtract, AND, OR and signed set-on-less-than, depending on how the caller sets the operation select, the invert control and the carry-in. Subtract and set-on-less-than both use invert = 1 with carry-in = 1. A zero flag, the unsigned carry-out and the signed overflow flag are produced alongside the result.

Top module: `bitslice_alu`

## Requirements
- R1: With `op_sel` = 0 and `b_negate` = 0, `result` equals `opnd_a & opnd_b`.
- R2: With `op_sel` = 1 and `b_negate` = 0, `result` equals `opnd_a | opnd_b`.
- R3: With `op_sel` = 2, `result` is the low WIDTH bits of `opnd_a + b' + carry_in`, where b' is `opnd_b` or its complement when `b_negate` = 1. `carry_out` is bit WIDTH of that sum.
- R4: With `op_sel` = 2, `b_negate` = 1 and `carry_in` = 1, `result` equals `opnd_a - opnd_b` modulo 2^WIDTH.
- R5: For every `op_sel`, `overflow` is 1 exactly when the two's-complement addition `opnd_a + b' + carry_in` overflows, i.e. when the carry into the top bit differs from the carry out of it.
- R6: With `op_sel` = 3, bits WIDTH-1..1 of `result` are 0. Bit 0 is the top sum bit XOR `overflow`. With `b_negate` = 1 and `carry_in` = 1, bit 0 is 1 exactly when `opnd_a < opnd_b` as signed values, including when the subtraction overflows.
- R7: `zero` is 1 exactly when every bit of `result` is 0.
- R8: With `b_negate` = 1, the logic operations use the complement of `opnd_b`: `op_sel` 0 gives `opnd_a & ~opnd_b` and `op_sel` 1 gives `opnd_a | ~opnd_b`.
- R9: With `b_negate` = 1 and `carry_in` = 1, `carry_out` is 1 exactly when `opnd_a >= opnd_b` as unsigned values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| b_negate | input | 1 | Use the complement of `opnd_b` in every slice |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | 0 AND, 1 OR, 2 sum, 3 less-than |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the top slice |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the addition |

## Verification
Signed less-than and overflow detection can both be active for the same operand pair. When the subtraction overflows, the set bit must be the inverted sign of the wrapped difference, and the `overflow` output must still read 1. This case is provoked with directed pairs that straddle the signed range, such as the most negative value against 1 and the most positive value against -1. The random stimulus also hits many overflowing subtractions in less-than mode. In each case, bit 0 is judged against a signed comparison done in the bench, and `overflow` against a wide-arithmetic model. The zero flag also interacts with the other outputs: a less-than result of 0 and a subtract of equal operands must both raise `zero`, while `carry_out` reports the unsigned borrow.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    typedef enum logic [1:0] {
        OP_AND  = 2'd0,
        OP_OR   = 2'd1,
        OP_ADD  = 2'd2,
        OP_LESS = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic ci);
        fa_out_t r;
        r.sum   = x ^ y ^ ci;
        r.carry = (x & y) | (x & ci) | (y & ci);
        return r;
    endfunction

    function automatic logic pick_bit(input alu_op_e op, input logic x, input logic y,
                                      input logic s, input logic lt);
        logic r;
        unique case (op)
            OP_AND:  r = x & y;
            OP_OR:   r = x | y;
            OP_ADD:  r = s;
            default: r = lt;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_slice_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    b_inv,
    input  logic    c_in,
    input  logic    less,
    input  alu_op_e op,
    output logic    res,
    output logic    sum,
    output logic    c_out
);
    logic    b_eff;
    fa_out_t fa;

    always_comb begin
        b_eff = b_bit ^ b_inv;
        fa    = full_add(a_bit, b_eff, c_in);
        sum   = fa.sum;
        c_out = fa.carry;
        res   = pick_bit(op, a_bit, b_eff, fa.sum, less);
    end
endmodule

// File: rtl/alu_msb_slice.sv
module alu_msb_slice
    import alu_slice_pkg::*;
(
    input  logic    a_bit,
    input  logic    b_bit,
    input  logic    b_inv,
    input  logic    c_in,
    input  logic    less,
    input  alu_op_e op,
    output logic    res,
    output logic    c_out,
    output logic    set_bit,
    output logic    ovf
);
    logic sum;
    logic carry;

    alu_bit_slice core_i (
        .a_bit (a_bit),
        .b_bit (b_bit),
        .b_inv (b_inv),
        .c_in  (c_in),
        .less  (less),
        .op    (op),
        .res   (res),
        .sum   (sum),
        .c_out (carry)
    );

    always_comb begin
        c_out   = carry;
        ovf     = c_in ^ carry;
        set_bit = sum ^ ovf;
    end

    // R5: overflow only when both addends share a sign and the sum bit differs from it
    always_comb begin
        if (ovf) begin
            a_r5_ovf_sign: assert ((a_bit == (b_bit ^ b_inv)) && (sum != a_bit))
                else $error("R5 overflow raised with inconsistent operand signs");
        end
    end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_slice_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             b_negate,
    input  logic             carry_in,
    input  logic [1:0]       op_sel,
    output logic [WIDTH-1:0] result,
    output logic             carry_out,
    output logic             zero,
    output logic             overflow
);
    localparam int TOP = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH:0]   chain;
    logic             set_fb;

    assign op       = alu_op_e'(op_sel);
    assign chain[0] = carry_in;

    genvar i;
    generate
        for (i = 0; i < TOP; i++) begin : g_low
            alu_bit_slice slice_i (
                .a_bit (opnd_a[i]),
                .b_bit (opnd_b[i]),
                .b_inv (b_negate),
                .c_in  (chain[i]),
                .less  ((i == 0) ? set_fb : 1'b0),
                .op    (op),
                .res   (result[i]),
                .sum   (),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    alu_msb_slice top_i (
        .a_bit   (opnd_a[TOP]),
        .b_bit   (opnd_b[TOP]),
        .b_inv   (b_negate),
        .c_in    (chain[TOP]),
        .less    (1'b0),
        .op      (op),
        .res     (result[TOP]),
        .c_out   (chain[WIDTH]),
        .set_bit (set_fb),
        .ovf     (overflow)
    );

    assign carry_out = chain[WIDTH];
    assign zero      = ~|result;

    logic [WIDTH-1:0] b_ref;
    logic [WIDTH:0]   wide_ref;

    always_comb begin
        b_ref    = b_negate ? ~opnd_b : opnd_b;
        wide_ref = {1'b0, opnd_a} + {1'b0, b_ref} + {{WIDTH{1'b0}}, carry_in};
        if (op == OP_AND) begin
            a_r1_and: assert (result == (opnd_a & b_ref))
                else $error("R1 AND result mismatch");
        end
        if (op == OP_OR) begin
            a_r2_or: assert (result == (opnd_a | b_ref))
                else $error("R2 OR result mismatch");
        end
        if (op == OP_ADD) begin
            a_r3_sum: assert ({carry_out, result} == wide_ref)
                else $error("R3 ripple sum mismatch");
        end
        if (op == OP_ADD && b_negate && carry_in) begin
            a_r4_sub: assert (result == opnd_a - opnd_b)
                else $error("R4 difference mismatch");
        end
        if (op == OP_LESS) begin
            a_r6_upper_clear: assert (result[WIDTH-1:1] == '0)
                else $error("R6 upper bits not clear");
        end
        if (op == OP_LESS && b_negate && carry_in) begin
            a_r6_signed_lt: assert (result[0] == ($signed(opnd_a) < $signed(opnd_b)))
                else $error("R6 signed compare mismatch");
        end
    end
endmodule

// File: tb/bitslice_alu_tb.sv
module bitslice_alu_tb_top;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [W-1:0] a, b;
    logic         binv, cin;
    logic [1:0]   op;
    logic [W-1:0] res;
    logic         co, z, ov;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    bitslice_alu #(.WIDTH(W)) dut_i (
        .opnd_a (a), .opnd_b (b), .b_negate (binv), .carry_in (cin),
        .op_sel (op), .result (res), .carry_out (co), .zero (z), .overflow (ov)
    );

    function automatic void model(input logic [W-1:0] xa, input logic [W-1:0] xb,
                                  input logic bi, input logic ci, input logic [1:0] o,
                                  output logic [W-1:0] r, output logic c,
                                  output logic v, output logic zf);
        logic [W-1:0] bb;
        logic [W:0]   full;
        logic [W-1:0] low;
        logic         c_top;
        bb    = bi ? ~xb : xb;
        full  = {1'b0, xa} + {1'b0, bb} + {{W{1'b0}}, ci};
        low   = {1'b0, xa[W-2:0]} + {1'b0, bb[W-2:0]} + {{(W-1){1'b0}}, ci};
        c_top = low[W-1];
        c     = full[W];
        v     = c_top ^ full[W];
        case (o)
            2'd0:    r = xa & bb;
            2'd1:    r = xa | bb;
            2'd2:    r = full[W-1:0];
            default: r = {{(W-1){1'b0}}, full[W-1] ^ v};
        endcase
        zf = (r == '0);
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (a=%h b=%h binv=%0b cin=%0b op=%0d)",
                     tag, act, exp, a, b, binv, cin, op);
        end
    endtask

    task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] xb,
                         input logic bi, input logic ci, input logic [1:0] o);
        logic [W-1:0] er;
        logic ec, ev, ez;
        string rtag, ctag;
        @(posedge clk);
        a = xa; b = xb; binv = bi; cin = ci; op = o;
        @(negedge clk);
        model(xa, xb, bi, ci, o, er, ec, ev, ez);
        case (o)
            2'd0:    rtag = bi ? "R8 and-inverted" : "R1 and";
            2'd1:    rtag = bi ? "R8 or-inverted" : "R2 or";
            2'd2:    rtag = (bi && ci) ? "R4 subtract" : "R3 sum";
            default: rtag = "R6 less-than";
        endcase
        ctag = (bi && ci) ? "R9 carry_out" : "R3 carry_out";
        chk(rtag, res, er);
        chk(ctag, {{(W-1){1'b0}}, co}, {{(W-1){1'b0}}, ec});
        chk("R5 overflow", {{(W-1){1'b0}}, ov}, {{(W-1){1'b0}}, ev});
        chk("R7 zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, ez});
    endtask

    initial begin
        a = '0; b = '0; binv = 1'b0; cin = 1'b0; op = 2'd0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7 idle zero", {{(W-1){1'b0}}, z}, {{(W-1){1'b0}}, 1'b1});
        chk("R1 idle result", res, '0);

        // R6 with R5: overflowing subtractions in less-than mode
        apply(32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 2'd3);
        apply(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'd3);
        apply(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 1'b1, 2'd3);
        apply(32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, 2'd3);
        // R4/R9/R7: equal operands, unsigned borrow
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b1, 1'b1, 2'd2);
        apply(32'h0000_0001, 32'h0000_0002, 1'b1, 1'b1, 2'd2);
        // R3/R5: wraparound and signed overflow on add
        apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'd2);
        apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'd2);
        apply(32'h7FFF_FFFF, 32'h0000_0000, 1'b0, 1'b1, 2'd2);
        // R1/R2/R8 directed patterns
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 1'b0, 1'b0, 2'd0);
        apply(32'hF0F0_F0F0, 32'hFF00_FF00, 1'b1, 1'b0, 2'd0);
        apply(32'h0F0F_0000, 32'h00FF_0000, 1'b0, 1'b0, 2'd1);
        apply(32'h0000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 2'd1);

        void'($urandom(32'd20240611));
        for (int k = 0; k < 3000; k++) begin
            logic [W-1:0] ra, rb;
            logic [1:0]   ro;
            logic         rbi, rci;
            ra  = $urandom();
            rb  = $urandom();
            ro  = 2'($urandom_range(3, 0));
            rbi = 1'($urandom_range(1, 0));
            rci = 1'($urandom_range(1, 0));
            if (ro == 2'd3 || k[0]) begin rbi = 1'b1; rci = 1'b1; end
            if (k % 7 == 0) rb = ra;
            if (k % 11 == 0) ra = {ra[W-1], {(W-1){~ra[W-1]}}};
            apply(ra, rb, rbi, rci, ro);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule